// File: doc/BRIEF.md
# Injection Tier Selector

This block sits beside a core's network interface in a stacked-die network. A stack has several tiers, and every core reaches all of them through a crossbar in its vertical pillar. For each new packet, the selector chooses which tier the packet enters. The caller raises a start strobe together with the packet's class, a policy code and a mask of the tiers that can be used. One clock later the block returns the chosen tier index and a one-cycle valid pulse.

There are three policies. The random policy spreads traffic over the usable tiers for load balance. Bottom-first always uses tier 0, which is next to the board and sheds heat best. The class-based policy keeps control packets, which need in-order delivery, on tier 0 with its deterministic routing. Data packets, which tolerate reordering, go to the upper tiers.

Tier 0 connects every core, so it is always treated as usable, whatever its mask bit says. The pseudo-random choice comes from a 16-bit linear feedback shift register (LFSR) inside the block.

Top module: `tier_select`

## Requirements
- R1: While reset is held, and in the first cycle after it, `valid_o` is 0 and `tier_o` is 0.
- R2: `valid_o` is 1 in exactly the cycle after a cycle with `start_i` high, and 0 in every other cycle.
- R3: With policy 2'b00 (random), a candidate is taken from the low two bits of the LFSR state. The result is the first usable tier at or after the candidate, counting upward and wrapping after the top tier. The usable tiers are the set bits of `avail_i`, with bit 0 always counted as set.
- R4: With policy 2'b01 (bottom-first), the result is tier 0 for any mask, even one whose bit 0 is clear.
- R5: Policy 2'b11 gives the same result as 2'b01.
- R6: With policy 2'b10 (class-based) and `class_i` = 0 (control), the result is tier 0.
- R7: With policy 2'b10 and `class_i` = 1 (data), the rotation of R3 runs over the usable tiers 1 and above only. When at least one of them is usable, the result is never 0.
- R8: With policy 2'b10 and `class_i` = 1, if no tier above 0 is usable, the result is tier 0.
- R9: `tier_o` keeps its value in every cycle without a start. Changes to `avail_i`, `policy_i` or `class_i` in those cycles do not affect it.
- R10: The LFSR is a 16-bit right-shifting register with reset value 16'hACE1. It steps once on every start, whatever the policy, and never steps at any other time. One step is next = (s >> 1) XOR (s[0] ? 16'hB400 : 0), and the candidate is taken from the state before the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe: one new packet needs a tier |
| class_i | input | 1 | Packet class: 0 control, 1 data |
| policy_i | input | 2 | Policy: 00 random, 01 bottom-first, 10 class-based, 11 treated as 01 |
| avail_i | input | NUM_TIERS (4) | Usable-tier mask, read on the start strobe; bit 0 is ignored |
| tier_o | output | TIER_W (2) | Chosen tier index, held until the next start |
| valid_o | output | 1 | One-cycle pulse marking a new `tier_o` |

## Verification
The wrap-around rotation is hard to reach from the ports. It needs a candidate that points at an unusable tier just below a gap at the top, and the candidate comes from the internal LFSR, which the caller cannot set.

The bench keeps its own model of the LFSR, stepped once per start. It drives sparse masks such as a single upper tier, or the empty mask, under both the random and the class-based data policies, so the rotation must skip tiers and wrap. Starts under non-random policies come before a random one, which shows whether the register stepped on them.

// File: rtl/tier_sel_pkg.sv
package tier_sel_pkg;
   typedef enum logic [1:0] {
      POL_RANDOM = 2'b00,
      POL_BOTTOM = 2'b01,
      POL_CLASS  = 2'b10,
      POL_SPARE  = 2'b11
   } policy_e;

   localparam logic CLS_CONTROL = 1'b0;
   localparam logic CLS_DATA    = 1'b1;
endpackage

// File: rtl/tier_lfsr.sv
module tier_lfsr #(
   parameter int           W    = 16,
   parameter logic [W-1:0] TAPS = 16'hB400,
   parameter logic [W-1:0] SEED = 16'hACE1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step_i,
   output logic [W-1:0] state_o
);
   logic [W-1:0] nxt;

   // R10: right-shift Galois step, applied only when a start arrives
   always_comb begin
      nxt = state_o >> 1;
      if (state_o[0]) nxt = nxt ^ TAPS;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      state_o <= SEED;
      else if (step_i) state_o <= nxt;
   end
endmodule

// File: rtl/tier_rotate.sv
module tier_rotate #(
   parameter int N      = 4,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [IDX_W-1:0] cand_i,
   input  logic [N-1:0]     mask_i,
   output logic [IDX_W-1:0] pick_o,
   output logic             found_o
);
   logic [N-1:0] rot_usable;

   // Usable flag of the tier "off" steps above the candidate, wrapping
   for (genvar off = 0; off < N; off++) begin : g_off
      always_comb rot_usable[off] = mask_i[(int'(cand_i) + off) % N];
   end

   // Walk from the farthest offset down so the nearest usable tier wins
   always_comb begin
      pick_o  = '0;
      found_o = 1'b0;
      for (int off = N - 1; off >= 0; off--) begin
         if (rot_usable[off]) begin
            pick_o  = IDX_W'((int'(cand_i) + off) % N);
            found_o = 1'b1;
         end
      end
   end
endmodule

// File: rtl/tier_policy.sv
module tier_policy
   import tier_sel_pkg::*;
#(
   parameter int N      = 4,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [1:0]       policy_i,
   input  logic             class_i,
   input  logic [N-1:0]     avail_i,
   input  logic [IDX_W-1:0] cand_i,
   output logic [IDX_W-1:0] tier_o
);
   logic [N-1:0]     usable;
   logic [N-1:0]     upper;
   logic [N-1:0]     rot_mask;
   logic [IDX_W-1:0] rot_pick;
   logic             rot_found;
   policy_e          pol;

   always_comb begin
      pol      = policy_e'(policy_i);
      usable   = avail_i | N'(1);
      upper    = usable & ~N'(1);
      rot_mask = (pol == POL_CLASS) ? upper : usable;
   end

   tier_rotate #(.N(N)) rot_i (
      .cand_i  (cand_i),
      .mask_i  (rot_mask),
      .pick_o  (rot_pick),
      .found_o (rot_found)
   );

   always_comb begin
      unique case (pol)
         POL_RANDOM: tier_o = rot_pick;
         POL_CLASS:  tier_o = (class_i == CLS_DATA && rot_found) ? rot_pick : '0;
         default:    tier_o = '0;
      endcase
   end
endmodule

// File: rtl/tier_select.sv
module tier_select #(
   parameter int                NUM_TIERS = 4,
   parameter int                LFSR_W    = 16,
   parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
   localparam int               TIER_W    = $clog2(NUM_TIERS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic                 class_i,
   input  logic [1:0]           policy_i,
   input  logic [NUM_TIERS-1:0] avail_i,
   output logic [TIER_W-1:0]    tier_o,
   output logic                 valid_o
);
   initial begin
      assert (NUM_TIERS >= 2 && (1 << TIER_W) == NUM_TIERS)
         else $error("NUM_TIERS must be a power of two, at least 2");
      assert (LFSR_W >= TIER_W) else $error("LFSR narrower than tier index");
      assert (LFSR_SEED != '0) else $error("LFSR seed must be nonzero");
   end

   logic [LFSR_W-1:0] lfsr_q;
   logic [TIER_W-1:0] pick;

   tier_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) lfsr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_i  (start_i),
      .state_o (lfsr_q)
   );

   tier_policy #(.N(NUM_TIERS)) pol_i (
      .policy_i (policy_i),
      .class_i  (class_i),
      .avail_i  (avail_i),
      .cand_i   (lfsr_q[TIER_W-1:0]),
      .tier_o   (pick)
   );

   // The mask is read only on the strobe, so the held result cannot drift
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tier_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= start_i;
         if (start_i) tier_o <= pick;
      end
   end
endmodule

// File: rtl/tier_select_chk.sv
module tier_select_chk #(
   parameter int  NUM_TIERS = 4,
   localparam int TIER_W    = $clog2(NUM_TIERS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start_i,
   input logic                 class_i,
   input logic [1:0]           policy_i,
   input logic [NUM_TIERS-1:0] avail_i,
   input logic [TIER_W-1:0]    tier_o,
   input logic                 valid_o
);
   logic [NUM_TIERS-1:0] seen_mask;

   always_ff @(posedge clk) begin
      if (!rst_n)       seen_mask <= '1;
      else if (start_i) seen_mask <= avail_i | NUM_TIERS'(1);
   end

   assert_valid_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> valid_o);
   assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> !valid_o);
   assert_random_usable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && policy_i == 2'b00) |=> seen_mask[tier_o]);
   assert_bottom_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && policy_i == 2'b01) |=> tier_o == '0);
   assert_spare_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && policy_i == 2'b11) |=> tier_o == '0);
   assert_control_bottom_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && policy_i == 2'b10 && !class_i) |=> tier_o == '0);
   assert_data_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && policy_i == 2'b10 && class_i && avail_i[NUM_TIERS-1:1] != '0)
      |=> (tier_o != '0 && seen_mask[tier_o]));
   assert_data_fallback_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && policy_i == 2'b10 && class_i && avail_i[NUM_TIERS-1:1] == '0)
      |=> tier_o == '0);
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> $stable(tier_o));
endmodule

bind tier_select tier_select_chk #(.NUM_TIERS(NUM_TIERS)) chk_i (.*);

// File: tb/tier_select_tb_top.sv
module tier_select_tb_top;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         start_i;
   logic         class_i;
   logic [1:0]   policy_i;
   logic [N-1:0] avail_i;
   logic [1:0]   tier_o;
   logic         valid_o;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;
   logic [15:0] lfsr_m = 16'hACE1;

   always #5 clk = ~clk;

   tier_select dut_i (.*);

   function automatic logic [15:0] lfsr_next(logic [15:0] s);
      return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
   endfunction

   function automatic int first_from(logic [N-1:0] m, int c);
      int j = c;
      for (int k = 0; k < N; k++) begin
         if (m[j]) return j;
         j = (j == N - 1) ? 0 : j + 1;
      end
      return -1;
   endfunction

   function automatic int expect_tier(logic [1:0] pol, logic cls, logic [N-1:0] av, int c);
      logic [N-1:0] eff = av | 4'b0001;
      logic [N-1:0] up  = eff & 4'b1110;
      if (pol == 2'b00) return first_from(eff, c);
      if (pol == 2'b10 && cls) return (up == 0) ? 0 : first_from(up, c);
      return 0;
   endfunction

   task automatic check(string req, int act, int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic apply(logic [1:0] pol, logic cls, logic [N-1:0] av, string req);
      int exp = expect_tier(pol, cls, av, int'(lfsr_m[1:0]));
      lfsr_m   = lfsr_next(lfsr_m);
      policy_i = pol;
      class_i  = cls;
      avail_i  = av;
      start_i  = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check("R2 valid pulse", int'(valid_o), 1);
      check(req, int'(tier_o), exp);
      avail_i  = ~av;
      policy_i = ~pol;
      class_i  = ~cls;
      @(negedge clk);
      check("R2 valid drop", int'(valid_o), 0);
      check("R9 hold", int'(tier_o), exp);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED1234));
      rst_n = 1'b0; start_i = 1'b0; class_i = 1'b0; policy_i = 2'b00; avail_i = '1;
      repeat (3) @(negedge clk);
      check("R1 reset valid", int'(valid_o), 0);
      check("R1 reset tier", int'(tier_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release valid", int'(valid_o), 0);
      check("R1 after release tier", int'(tier_o), 0);

      for (int i = 0; i < 4; i++) apply(2'b00, 1'b0, 4'b1111, "R3 random full mask");
      apply(2'b00, 1'b0, 4'b0001, "R3 random only bottom");
      apply(2'b00, 1'b1, 4'b0000, "R3 bottom forced usable");
      for (int i = 0; i < 4; i++) apply(2'b00, 1'b0, 4'b0100, "R3 random wrap to single");
      apply(2'b01, 1'b1, 4'b1110, "R4 bottom-first bit0 clear");
      apply(2'b01, 1'b0, 4'b1111, "R4 bottom-first full");
      apply(2'b11, 1'b1, 4'b1110, "R5 spare code");
      apply(2'b10, 1'b0, 4'b1110, "R6 control on bottom");
      for (int i = 0; i < 4; i++) apply(2'b10, 1'b1, 4'b1111, "R7 data upper full");
      for (int i = 0; i < 3; i++) apply(2'b10, 1'b1, 4'b0010, "R7 data single upper");
      apply(2'b10, 1'b1, 4'b0001, "R8 data fallback");
      apply(2'b10, 1'b1, 4'b0000, "R8 data fallback empty");
      for (int i = 0; i < 5; i++) apply(2'b01, 1'b0, 4'b1111, "R10 step on bottom-first");
      for (int i = 0; i < 3; i++) apply(2'b00, 1'b0, 4'b1010, "R10 random after steps");
      // idle cycles must not step the register
      repeat (7) @(negedge clk);
      apply(2'b00, 1'b0, 4'b1011, "R10 no step while idle");

      for (int i = 0; i < 400; i++) begin
         logic [1:0]   p = 2'($urandom_range(0, 3));
         logic         c = 1'($urandom_range(0, 1));
         logic [N-1:0] a = 4'($urandom_range(0, 15));
         apply(p, c, a, (p == 2'b00) ? "R3 random mix" :
                        (p == 2'b10) ? (c ? "R7 data mix" : "R6 control mix") :
                        (p == 2'b01) ? "R4 bottom mix" : "R5 spare mix");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule